// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This sequential controller carries out one multi-register memory transfer. On a start pulse it samples a 16-bit register mask, a base address and the control bits that pick pre- or post-stepping, step direction, base writeback, load or store, and the special-bank flag. It then issues one 32-bit memory access for each register whose mask bit is set, lowest register index first, through a request/ready handshake. Load data is written straight into the register file; store data is read from the register file, except for register 15, whose stored value is the instruction address plus a fixed offset.

Registers always occupy consecutive ascending addresses in index order, so for a downward transfer the first access sits below the base by four bytes times the register count. With the special-bank flag set, a load that includes register 15 asks the surrounding core to copy the saved status word into the current one and aligns the loaded program counter. Any other transfer with the flag set steers the upper registers to the user bank, with the first steered register chosen by the processor mode class.

Top module: `block_xfer_seq`

## Requirements
- R1: A start pulse while idle performs exactly one memory access for each set bit of `reg_list`, in ascending register index order, with `mem_we` high for stores (`is_load`=0) and low for loads.
- R2: With N set bits, the access for the k-th listed register (k from 0) uses address L+4k, where L is base+4 (pre, up), base (post, up), base-4N (pre, down) or base-4N+4 (post, down).
- R3: While `mem_req` is high and `mem_ready` is low, the request, address and direction are held unchanged in the next cycle.
- R4: A load writes `mem_rdata` into the register file at the listed register index (`rf_waddr`) in the same cycle as the completing handshake.
- R5: A store drives `mem_wdata` from `rf_rdata` read at `rf_raddr` = current register index, except for register 15, where it drives `instr_addr`+12.
- R6: With `write_back` set and a non-empty list, the cycle after the last access writes base+4N (up) or base-4N (down) to register `base_idx` through the register file write port, with `rf_user_bank` low.
- R7: An empty list performs no memory access and no register write, and `done` rises in the cycle after the start pulse.
- R8: `done` is a single-cycle pulse that appears in the cycle after the last completing handshake; `busy` is high from the cycle after start until `done` inclusive.
- R9: With `s_flag` set on a load whose list includes register 15, `psr_restore` pulses together with `done`, no user bank is selected, and the loaded register 15 has bit 0 cleared when `saved_compact` is 1, bits 1:0 cleared otherwise.
- R10: With `s_flag` set on any other transfer, `rf_user_bank` is high during accesses to registers 8 and up for `mode_cls`=2'b10 (fast interrupt), 13 and up for 2'b01 or 2'b11 (other exception), and never for 2'b00 (user/system); with `s_flag` clear it is never high.
- R11: A start pulse while busy is ignored: the running transfer completes exactly as first requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| reg_list | input | 16 | Register mask, bit i selects register i |
| base_idx | input | 4 | Index of the base register for writeback |
| base_addr | input | AW | Base register value |
| instr_addr | input | AW | Address of the transfer instruction |
| pre_step | input | 1 | 1: step before each access, 0: after |
| step_up | input | 1 | 1: ascending, 0: descending |
| write_back | input | 1 | Write final address to the base register |
| s_flag | input | 1 | User-bank access or status restore |
| is_load | input | 1 | 1: load, 0: store |
| mode_cls | input | 2 | 00 user/system, 10 fast interrupt, other exception otherwise |
| saved_compact | input | 1 | Compact-instruction bit of the saved status word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| psr_restore | output | 1 | Copy saved status to current status |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ready | input | 1 | Access completes this cycle |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| rf_we | output | 1 | Register file write enable |
| rf_user_bank | output | 1 | Access the user bank instead of the active one |

## Verification
The bench builds the block with its default 32-bit address width and 12-byte program-counter offset, which keeps the full 16-entry mask so that register 15, the fast-interrupt banking boundary at 8 and the exception boundary at 13 are all reachable. It sweeps every combination of pre/post, up/down, writeback, load/store, special-bank flag and all three mode classes over nine masks, including empty, single-end, full and scattered lists, while a ready pattern inserts wait states. Addresses, data, bank selection, writeback value and done timing are predicted arithmetically from the mask.

// File: rtl/block_xfer_seq.sv
module block_xfer_seq #(
  parameter int AW     = 32,
  parameter int PC_OFS = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   reg_list,
  input  logic [3:0]    base_idx,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] instr_addr,
  input  logic          pre_step,
  input  logic          step_up,
  input  logic          write_back,
  input  logic          s_flag,
  input  logic          is_load,
  input  logic [1:0]    mode_cls,
  input  logic          saved_compact,
  output logic          busy,
  output logic          done,
  output logic          psr_restore,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ready,
  output logic [3:0]    rf_raddr,
  input  logic [31:0]   rf_rdata,
  output logic [3:0]    rf_waddr,
  output logic [31:0]   rf_wdata,
  output logic          rf_we,
  output logic          rf_user_bank
);
  localparam int NR = 16;
  localparam int CW = $clog2(NR) + 1;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_DONE} st_t;
  st_t st;

  logic [NR-1:0] pend, pend_next;
  logic [AW-1:0] cur_addr, fin_addr, pc_val;
  logic          ld_q, wb_q, rst_q, cmp_q;
  logic [3:0]    bidx_q;
  logic [CW-1:0] bstart_q, bstart_d, cnt;
  logic [3:0]    idx;
  logic [AW-1:0] span, lo_addr, fin_d;
  logic          hs, restore_d;
  logic [31:0]   ld_data;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NR; i++) cnt = cnt + CW'(reg_list[i]);
  end

  always_comb begin
    idx = '0;
    for (int i = NR-1; i >= 0; i--) if (pend[i]) idx = 4'(i);
  end

  assign span      = AW'(cnt) << 2;
  assign lo_addr   = step_up ? (pre_step ? base_addr + AW'(4) : base_addr)
                             : (pre_step ? base_addr - span : base_addr - span + AW'(4));
  assign fin_d     = step_up ? base_addr + span : base_addr - span;
  assign restore_d = s_flag && is_load && reg_list[15];
  assign bstart_d  = (!s_flag || restore_d) ? CW'(16) :
                     (mode_cls == 2'b10) ? CW'(8) :
                     (mode_cls == 2'b00) ? CW'(16) : CW'(13);
  assign pend_next = pend & (pend - NR'(1));
  assign hs        = (st == S_XFER) && mem_ready;

  assign busy         = st != S_IDLE;
  assign done         = st == S_DONE;
  assign psr_restore  = done && rst_q;
  assign mem_req      = st == S_XFER;
  assign mem_we       = !ld_q;
  assign mem_addr     = cur_addr;
  assign rf_raddr     = idx;
  assign mem_wdata    = (idx == 4'd15) ? 32'(pc_val) : rf_rdata;
  assign rf_user_bank = (st == S_XFER) && ({1'b0, idx} >= bstart_q);
  assign ld_data      = (rst_q && idx == 4'd15)
                        ? (cmp_q ? {mem_rdata[31:1], 1'b0} : {mem_rdata[31:2], 2'b00})
                        : mem_rdata;
  assign rf_we        = (hs && ld_q) || (done && wb_q);
  assign rf_waddr     = done ? bidx_q : idx;
  assign rf_wdata     = done ? 32'(fin_addr) : ld_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      pend     <= '0;
      cur_addr <= '0;
      fin_addr <= '0;
      pc_val   <= '0;
      ld_q     <= 1'b0;
      wb_q     <= 1'b0;
      rst_q    <= 1'b0;
      cmp_q    <= 1'b0;
      bidx_q   <= '0;
      bstart_q <= CW'(16);
    end else begin
      case (st)
        S_IDLE: if (start) begin
          pend     <= reg_list;
          cur_addr <= lo_addr;
          fin_addr <= fin_d;
          pc_val   <= instr_addr + AW'(PC_OFS);
          ld_q     <= is_load;
          wb_q     <= write_back && (reg_list != '0);
          rst_q    <= restore_d;
          cmp_q    <= saved_compact;
          bidx_q   <= base_idx;
          bstart_q <= bstart_d;
          st       <= (reg_list == '0) ? S_DONE : S_XFER;
        end
        S_XFER: if (mem_ready) begin
          pend     <= pend_next;
          cur_addr <= cur_addr + AW'(4);
          if (pend_next == '0) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r3_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ready |=> !mem_req || (mem_addr == $past(mem_addr) + AW'(4)));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_no_req_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req && busy);

  a_r9_restore_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    psr_restore |-> done);

  a_r4_write_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && !done |-> mem_req && mem_ready && !mem_we);

  a_r11_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> $stable(mem_addr));
endmodule

// File: tb/test_block_xfer_seq.sv
`timescale 1ns/1ps
module test_block_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] reg_list = '0;
  logic [3:0]  base_idx = '0;
  logic [31:0] base_addr = '0, instr_addr = '0;
  logic        pre_step = 0, step_up = 0, write_back = 0, s_flag = 0, is_load = 0;
  logic [1:0]  mode_cls = '0;
  logic        saved_compact = 0;
  logic        busy, done, psr_restore, mem_req, mem_we, rf_we, rf_user_bank;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata;
  logic [3:0]  rf_raddr, rf_waddr;
  logic        mem_ready;

  int cyc = 0;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign mem_ready = (cyc % 3) != 2;
  assign mem_rdata = {~mem_addr[15:0], mem_addr[15:2], 2'b11};
  assign rf_rdata  = {rf_user_bank ? 16'h5555 : 16'hAAAA, 12'h000, rf_raddr};

  block_xfer_seq i_block_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .reg_list(reg_list), .base_idx(base_idx),
    .base_addr(base_addr), .instr_addr(instr_addr), .pre_step(pre_step), .step_up(step_up),
    .write_back(write_back), .s_flag(s_flag), .is_load(is_load), .mode_cls(mode_cls),
    .saved_compact(saved_compact), .busy(busy), .done(done), .psr_restore(psr_restore),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_user_bank(rf_user_bank));

  logic [31:0] acc_addr[32], acc_wdata[32], wr_data[32];
  logic        acc_we[32], acc_user[32], wr_user[32];
  logic [3:0]  wr_addr[32];
  int nacc, nwr, ndone, done_cyc, last_hs, s_cyc;
  logic rest_seen;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_ready && nacc < 32) begin
        acc_addr[nacc] <= mem_addr; acc_wdata[nacc] <= mem_wdata;
        acc_we[nacc] <= mem_we; acc_user[nacc] <= rf_user_bank;
        nacc <= nacc + 1; last_hs <= cyc;
      end
      if (rf_we && nwr < 32) begin
        wr_addr[nwr] <= rf_waddr; wr_data[nwr] <= rf_wdata; wr_user[nwr] <= rf_user_bank;
        nwr <= nwr + 1;
      end
      if (done) begin
        ndone <= ndone + 1; done_cyc <= cyc; rest_seen <= psr_restore;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] lst, input bit p, input bit u, input bit w,
                     input bit s, input bit l, input logic [1:0] mc, input bit cmp,
                     input logic [31:0] base, input logic [3:0] bi, input logic [31:0] ia,
                     input bit poke);
    int cnt, bs, k, guard, exp_wr;
    logic [31:0] lo, fin, a, e;
    bit rs, usr, wbe;
    @(negedge clk);
    nacc = 0; nwr = 0; ndone = 0; rest_seen = 0; last_hs = -1;
    reg_list = lst; pre_step = p; step_up = u; write_back = w; s_flag = s; is_load = l;
    mode_cls = mc; saved_compact = cmp; base_addr = base; base_idx = bi; instr_addr = ia;
    start = 1'b1; s_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      reg_list = 16'hFFFF; is_load = ~l; base_addr = 32'hDEAD_0000; step_up = ~u; start = 1'b1;
      @(negedge clk);
      start = 1'b0; reg_list = lst; is_load = l; base_addr = base; step_up = u;
    end
    guard = 0;
    while (ndone == 0 && guard < 300) begin @(negedge clk); guard++; end
    chk(guard < 300, "R8 watchdog: done never seen", 32'(guard), 32'd300);
    @(negedge clk); @(negedge clk);
    cnt = $countones(lst);
    rs  = s && l && lst[15];
    bs  = (!s || rs) ? 16 : (mc == 2'b10) ? 8 : (mc == 2'b00) ? 16 : 13;
    lo  = u ? (p ? base + 4 : base) : (p ? base - 32'(4*cnt) : base - 32'(4*cnt) + 4);
    fin = u ? base + 32'(4*cnt) : base - 32'(4*cnt);
    wbe = w && cnt != 0;
    chk(nacc == cnt, poke ? "R11 access count with start while busy" : "R1 access count",
        32'(nacc), 32'(cnt));
    if (nacc == cnt) begin
      k = 0;
      for (int i = 0; i < 16; i++) if (lst[i]) begin
        a   = lo + 32'(4*k);
        usr = (i >= bs);
        chk(acc_addr[k] == a, "R2 access address", acc_addr[k], a);
        chk(acc_we[k] == !l, "R1 write enable", 32'(acc_we[k]), 32'(!l));
        chk(acc_user[k] == usr, "R10 user bank select", 32'(acc_user[k]), 32'(usr));
        if (!l) begin
          e = (i == 15) ? ia + 32'd12 : {usr ? 16'h5555 : 16'hAAAA, 12'h000, 4'(i)};
          chk(acc_wdata[k] == e, (i == 15) ? "R5 stored pc offset" : "R5 store data",
              acc_wdata[k], e);
        end else if (k < nwr) begin
          e = {~a[15:0], a[15:2], 2'b11};
          if (rs && i == 15) e = cmp ? (e & ~32'h1) : (e & ~32'h3);
          chk(wr_addr[k] == 4'(i), "R4 load target index", 32'(wr_addr[k]), 32'(i));
          chk(wr_data[k] == e, (rs && i == 15) ? "R9 aligned pc load" : "R4 load data",
              wr_data[k], e);
        end
        k++;
      end
    end
    exp_wr = (l ? cnt : 0) + (wbe ? 1 : 0);
    chk(nwr == exp_wr, (cnt == 0) ? "R7 register writes on empty list" : "R6 register write count",
        32'(nwr), 32'(exp_wr));
    if (wbe && nwr == exp_wr) begin
      chk(wr_addr[nwr-1] == bi && wr_data[nwr-1] == fin && !wr_user[nwr-1],
          "R6 writeback value", wr_data[nwr-1], fin);
    end
    chk(ndone == 1, "R8 single done pulse", 32'(ndone), 32'd1);
    if (cnt == 0) chk(done_cyc == s_cyc + 1, "R7 empty list done timing", 32'(done_cyc), 32'(s_cyc + 1));
    else chk(done_cyc == last_hs + 1, "R8 done timing", 32'(done_cyc), 32'(last_hs + 1));
    chk(rest_seen == rs, "R9 status restore", 32'(rest_seen), 32'(rs));
    chk(!busy && !mem_req, "R8 idle after done", 32'({busy, mem_req}), 32'd0);
  endtask

  always @(posedge clk) if (cyc > 190000) begin
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  logic [15:0] lists[9] = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF, 16'h00F0,
                            16'h8001, 16'hA5C3, 16'h7FFF, 16'h1234};

  initial begin
    int t;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !rf_we && !psr_restore, "R8 reset state",
        32'({busy, done, mem_req, rf_we, psr_restore}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    t = 0;
    for (int li = 0; li < 9; li++)
      for (int c = 0; c < 32; c++)
        for (int m = 0; m < 3; m++) begin
          logic [1:0] mc;
          mc = (m == 0) ? 2'b00 : (m == 1) ? 2'b01 : 2'b10;
          run(lists[li], c[0], c[1], c[2], c[3], c[4], mc, t[0],
              32'h1000_0200 + 32'(t * 16), 4'(t % 15), 32'h0000_4000 + 32'(t * 4), 1'b0);
          t++;
        end
    run(16'hA5C3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 32'h2000_0000, 4'd3, 32'h100, 1'b1);
    run(16'h7FFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b10, 1'b1, 32'h3000_0040, 4'd13, 32'h200, 1'b1);
    run(16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b1, 32'h4000_0080, 4'd1, 32'h300, 1'b1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule